// File: doc/BRIEF.md
# Pipelined Unsigned 8x8 Carry-Save Tree Multiplier

This block multiplies two unsigned 8-bit operands and returns their exact 16-bit product after a fixed four-clock latency. One operand is the multiplier and the other the multiplicand. Each multiplier bit gates a copy of the multiplicand shifted left by that bit's index, and these eight rows are held in a register on the first clock. The rows then pass through a tree of 3:2 carry-save compressors until two vectors remain. A carry-propagate adder sums those two vectors.

There is no state machine. The pipeline runs through four named register stages. STAGE_PP holds the partial-product rows. STAGE_RED_A holds four rows after two compressor layers. STAGE_RED_B holds two rows after two more compressor layers. STAGE_SUM holds the carry-propagate result. A new operand pair may enter on every clock. The valid flag travels beside the data through the same four stages, so the block has no stall and no back-pressure.

Top module: `wallace_mul8`

## Requirements
- R1: When `out_valid` is 1, `product` equals the unsigned product `mcand * mplier` of the pair that entered with it, exactly, as a 16-bit value.
- R2: A pair presented with `in_valid`=1 at a rising edge appears on `product` with `out_valid`=1 after exactly four rising edges, counting the capturing edge.
- R3: Pairs presented on consecutive clocks come out on consecutive clocks, in order, with no bubble between them.
- R4: `out_valid` repeats `in_valid` delayed by four clocks. A clock with `in_valid`=0 gives a clock with `out_valid`=0 four clocks later, whatever the operand values.
- R5: `rst_n` is a synchronous active-low reset. After any rising edge with `rst_n`=0, `out_valid` is 0 and `product` is 0, even if valid pairs were in flight.
- R6: Boundary operands give exact results. A zero operand gives 0. 255 x 255 gives 65025. A power-of-two multiplier selects a single shifted row.
- R7: Multiplier bit i selects the multiplicand shifted left by i, and a 0 bit selects a zero row. Swapping the roles of the two operands therefore gives the same product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair on this clock is valid |
| mcand | input | 8 | Multiplicand, unsigned |
| mplier | input | 8 | Multiplier, unsigned; bit i gates row i |
| out_valid | output | 1 | `product` carries a valid result |
| product | output | 16 | Unsigned product |

## Verification
The vector table runs back-to-back. It pairs zero operands against all-ones operands, and single-bit multipliers against dense bit patterns. A fault in row gating or shifting therefore shows up separately from a fault in carry propagation across the full width. Each asymmetric pair also appears swapped, which separates an error in the multiplier-bit selection from an error in the compressor tree. A sweep sends the complementary pairs a x (255 - a) with valid deasserted on alternate clocks, which checks the carries and the valid alignment together. Directed tests then apply reset while results are in flight, and hold `in_valid` low with nonzero operands.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

    // number of rows left after one layer of 3:2 compressors
    function automatic int csa_rows_out(input int n_in);
        return 2 * (n_in / 3) + (n_in % 3);
    endfunction

    // pipeline register stages, in order
    typedef enum logic [1:0] {
        STAGE_PP    = 2'd0,
        STAGE_RED_A = 2'd1,
        STAGE_RED_B = 2'd2,
        STAGE_SUM   = 2'd3
    } wmul_stage_e;

    localparam int WMUL_STAGES = 4;

endpackage

// File: rtl/wmul_ppgen.sv
module wmul_ppgen #(
    parameter int OP_W   = 8,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]              mcand,
    input  logic [OP_W-1:0]              mplier,
    output logic [OP_W-1:0][PROD_W-1:0]  rows
);

    // row i: multiplicand shifted by i when multiplier bit i is set, else zero
    for (genvar i = 0; i < OP_W; i++) begin : g_row
        assign rows[i] = mplier[i] ? (PROD_W'(mcand) << i) : '0;
    end

endmodule

// File: rtl/wmul_csa_layer.sv
module wmul_csa_layer #(
    parameter int W     = 16,
    parameter int N_IN  = 8,
    parameter int N_OUT = wmul_pkg::csa_rows_out(N_IN)
) (
    input  logic [N_IN-1:0][W-1:0]  rows_in,
    output logic [N_OUT-1:0][W-1:0] rows_out
);

    localparam int GROUPS = N_IN / 3;
    localparam int LEFT   = N_IN - 3 * GROUPS;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // sum vector: bitwise three-input parity
        assign rows_out[2*g] = rows_in[3*g] ^ rows_in[3*g+1] ^ rows_in[3*g+2];
        // carry vector: majority, moved up one column; top carry leaves the width
        assign rows_out[2*g+1][0] = 1'b0;
        for (genvar b = 1; b < W; b++) begin : g_bit
            assign rows_out[2*g+1][b] =
                (rows_in[3*g][b-1]   & rows_in[3*g+1][b-1]) |
                (rows_in[3*g][b-1]   & rows_in[3*g+2][b-1]) |
                (rows_in[3*g+1][b-1] & rows_in[3*g+2][b-1]);
        end
    end

    // rows that did not fill a group pass straight through
    if (LEFT > 0) begin : g_pass
        for (genvar r = 0; r < LEFT; r++) begin : g_left
            assign rows_out[2*GROUPS+r] = rows_in[3*GROUPS+r];
        end
    end

endmodule

// File: rtl/wmul_cpa.sv
module wmul_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i] = op_x[i] ^ op_y[i] ^ carry[i];
        if (i < W - 1) begin : g_c
            assign carry[i+1] = (op_x[i] & op_y[i]) |
                                (op_x[i] & carry[i]) |
                                (op_y[i] & carry[i]);
        end
    end

endmodule

// File: rtl/wallace_mul8.sv
module wallace_mul8 #(
    parameter int OP_W   = 8,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);

    import wmul_pkg::*;

    localparam int ROWS_L1 = csa_rows_out(OP_W);
    localparam int ROWS_L2 = csa_rows_out(ROWS_L1);
    localparam int ROWS_L3 = csa_rows_out(ROWS_L2);
    localparam int ROWS_L4 = csa_rows_out(ROWS_L3);

    // ---------------- STAGE_PP ----------------
    logic [OP_W-1:0][PROD_W-1:0] pp_d, pp_q;

    wmul_ppgen #(.OP_W(OP_W), .PROD_W(PROD_W)) u_ppgen (
        .mcand  (mcand),
        .mplier (mplier),
        .rows   (pp_d)
    );

    // ---------------- STAGE_RED_A: two compressor layers ----------------
    logic [ROWS_L1-1:0][PROD_W-1:0] l1_rows;
    logic [ROWS_L2-1:0][PROD_W-1:0] l2_d, l2_q;

    wmul_csa_layer #(.W(PROD_W), .N_IN(OP_W), .N_OUT(ROWS_L1)) u_lay1 (
        .rows_in  (pp_q),
        .rows_out (l1_rows)
    );

    wmul_csa_layer #(.W(PROD_W), .N_IN(ROWS_L1), .N_OUT(ROWS_L2)) u_lay2 (
        .rows_in  (l1_rows),
        .rows_out (l2_d)
    );

    // ---------------- STAGE_RED_B: two more layers ----------------
    logic [ROWS_L3-1:0][PROD_W-1:0] l3_rows;
    logic [ROWS_L4-1:0][PROD_W-1:0] l4_d, l4_q;

    wmul_csa_layer #(.W(PROD_W), .N_IN(ROWS_L2), .N_OUT(ROWS_L3)) u_lay3 (
        .rows_in  (l2_q),
        .rows_out (l3_rows)
    );

    wmul_csa_layer #(.W(PROD_W), .N_IN(ROWS_L3), .N_OUT(ROWS_L4)) u_lay4 (
        .rows_in  (l3_rows),
        .rows_out (l4_d)
    );

    // ---------------- STAGE_SUM ----------------
    logic [PROD_W-1:0] sum_d, sum_q;

    wmul_cpa #(.W(PROD_W)) u_cpa (
        .op_x (l4_q[0]),
        .op_y (l4_q[1]),
        .sum  (sum_d)
    );

    // ---------------- stage registers ----------------
    logic [WMUL_STAGES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_q  <= '0;
            l2_q  <= '0;
            l4_q  <= '0;
            sum_q <= '0;
            vld_q <= '0;
        end else begin
            pp_q  <= pp_d;
            l2_q  <= l2_d;
            l4_q  <= l4_d;
            sum_q <= sum_d;
            vld_q <= {vld_q[WMUL_STAGES-2:0], in_valid};
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_valid = vld_q[STAGE_SUM];
        product   = sum_q;
    end

endmodule

// File: rtl/wmul_checker.sv
module wmul_checker #(
    parameter int OP_W   = 8,
    parameter int PROD_W = 2 * OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   mcand,
    input logic [OP_W-1:0]   mplier,
    input logic              out_valid,
    input logic [PROD_W-1:0] product
);

    // clock edges since reset was released, saturating
    logic [2:0] since_rst;
    logic       rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
        rst_seen <= !rst_n;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)))
        else $error("valid delay"); // R4

    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && out_valid) |->
            (product == PROD_W'($past(mcand, 4)) * PROD_W'($past(mplier, 4))))
        else $error("product mismatch"); // R1

    AST_FOUR_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(in_valid, 4)) |-> out_valid)
        else $error("latency"); // R2

    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && $past(in_valid, 4) && $past(in_valid, 5)) |->
            (out_valid && $past(out_valid)))
        else $error("bubble"); // R3

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && out_valid &&
         ($past(mcand, 4) == '0 || $past(mplier, 4) == '0)) |-> (product == '0))
        else $error("zero operand"); // R6

    always @(negedge clk) begin
        if (rst_seen) begin
            AST_RESET_CLEAR: assert (out_valid == 1'b0 && product == '0)
                else $error("reset clear"); // R5
        end
    end

endmodule

bind wallace_mul8 wmul_checker #(.OP_W(OP_W), .PROD_W(PROD_W)) u_wmul_checker (.*);

// File: tb/wallace_mul8_bench.sv
`timescale 1ns/1ps
module wallace_mul8_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic        out_valid;
    logic [15:0] product;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // inputs driven on the last four negedges: index 3 is the oldest
    logic        hv [4];
    logic [15:0] hp [4];

    always #4 clk = ~clk;   // 125 MHz

    wallace_mul8 u_wallace_mul8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mcand     (mcand),
        .mplier    (mplier),
        .out_valid (out_valid),
        .product   (product)
    );

    // {mcand, mplier, expected}
    localparam logic [31:0] VEC [16] = '{
        {8'd0,   8'd0,   16'd0},      // R6 zero x zero
        {8'd255, 8'd255, 16'd65025},  // R6 all ones
        {8'd1,   8'd255, 16'd255},    // R7 unit multiplicand
        {8'd255, 8'd1,   16'd255},    // R7 swapped
        {8'd128, 8'd128, 16'd16384},  // R6 single row, top bit
        {8'd1,   8'd1,   16'd1},      // R1
        {8'd0,   8'd200, 16'd0},      // R6 zero multiplicand
        {8'd200, 8'd0,   16'd0},      // R6 zero multiplier
        {8'd13,  8'd11,  16'd143},    // R1
        {8'd11,  8'd13,  16'd143},    // R7 swapped
        {8'd170, 8'd85,  16'd14450},  // R1 alternating bits
        {8'd85,  8'd170, 16'd14450},  // R7 swapped
        {8'd128, 8'd255, 16'd32640},  // R7 one-hot multiplicand
        {8'd255, 8'd128, 16'd32640},  // R6 one-hot multiplier
        {8'd99,  8'd101, 16'd9999},   // R1
        {8'd240, 8'd15,  16'd3600}    // R1 disjoint nibbles
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 4; k++) begin
            hv[k] = 1'b0;
            hp[k] = '0;
        end
    endtask

    // one clock: check what entered four clocks ago, then drive a new pair
    task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
        @(negedge clk);
        chk(out_valid === hv[3], {tag, " R2 R4 out_valid"}, 32'(out_valid), 32'(hv[3]));
        if (hv[3])
            chk(product === hp[3], {tag, " R1 product"}, 32'(product), 32'(hp[3]));
        for (int k = 3; k > 0; k--) begin
            hv[k] = hv[k-1];
            hp[k] = hp[k-1];
        end
        hv[0] = v;
        hp[0] = 16'(a) * 16'(b);
        in_valid = v;
        mcand    = a;
        mplier   = b;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state, R5
        chk(out_valid === 1'b0, "R5 reset out_valid", 32'(out_valid), 0);
        chk(product === 16'd0, "R5 reset product", 32'(product), 0);
        rst_n = 1'b1;

        // table, back-to-back every clock: R3
        for (int i = 0; i < 16; i++)
            step(1'b1, VEC[i][31:24], VEC[i][23:16], "R3 table");
        for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, "R3 drain");

        // table expected column checked against the bench model's own product
        for (int i = 0; i < 16; i++)
            chk(16'(VEC[i][31:24]) * 16'(VEC[i][23:16]) == VEC[i][15:0],
                "R6 table entry", 32'(VEC[i][15:0]), 32'(VEC[i][31:24] * VEC[i][23:16]));

        // complementary sweep with valid on alternate clocks: R4
        for (int a = 0; a < 256; a += 3)
            step(a[0], 8'(a), 8'(255 - a), "R4 sweep");
        for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, "R4 drain");

        // invalid pairs with nonzero operands stay invisible: R4
        for (int i = 0; i < 6; i++) step(1'b0, 8'd255, 8'd255, "R4 idle operands");
        for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, "R4 idle drain");

        // single-row multipliers, each bit position: R7
        for (int b = 0; b < 8; b++) step(1'b1, 8'd183, 8'(1 << b), "R7 one-hot");
        for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0, "R7 drain");

        // reset with results in flight: R5
        for (int i = 0; i < 3; i++) step(1'b1, 8'd250, 8'd251, "R5 prefill");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R5 midstream out_valid", 32'(out_valid), 0);
        chk(product === 16'd0, "R5 midstream product", 32'(product), 0);
        in_valid = 1'b0;
        mcand = '0;
        mplier = '0;
        clear_hist();
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) step(1'b0, 8'd0, 8'd0, "R5 after reset");
        step(1'b1, 8'd77, 8'd3, "R5 restart");
        for (int i = 0; i < 5; i++) step(1'b0, 8'd0, 8'd0, "R5 restart drain");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule